// File: doc/BRIEF.md
# Cubic Convolution Weight Generator

This block turns a fractional sample position into the four weights a separable cubic resampler applies to its neighbouring samples. The position arrives as an unsigned fixed-point fraction `u` in [0,1). The four weights are for the taps one sample behind, at, one ahead and two ahead of the integer sample. They are returned as signed integers scaled by 256, so that the pixel multiply-accumulate stage after this block needs neither floating point nor division.

The kernel is a two-segment cubic. For |x| below one it is 1 - 2|x|^2 + |x|^3. Between one and two it is 4 - 8|x| + 5|x|^2 - |x|^3. Beyond two it is zero. Because `u` never reaches one, each tap always falls in the same kernel segment. The block therefore evaluates each tap's polynomial directly in terms of `u` and needs no range compare at run time. All polynomial terms are kept exact, and each weight is rounded once. The rounded set is then corrected so that it always sums to exactly 256.

Inputs and outputs use valid/ready handshakes. The block has a two-register pipeline that accepts one position per cycle while the consumer is ready.

Top module: `cubic_weight_gen`

## Requirements
- R1: The four output weights belong to the taps at offsets -1, 0, +1 and +2, and appear on `wt_m1`, `wt_c0`, `wt_p1` and `wt_p2` respectively. Each weight is a 16-bit two's-complement integer scaled by 256.
- R2: Let c = `frac_u` (0..255) and d = 256 - c. Before correction, the outer weights are round(-c*d*d / 65536) for the -1 tap and round(-d*c*c / 65536) for the +2 tap.
- R3: Before correction, the centre weights are round((2^24 - 512*c*c + c^3) / 65536) for the 0 tap and round((2^24 - 512*d*d + d^3) / 65536) for the +1 tap.
- R4: Rounding is to the nearest integer, with halves rounded upward. For a numerator N over 65536 the result is floor((256*N + 2^23) / 2^24). Rounding is applied only once, to the exact numerator.
- R5: After rounding, 256 minus the sum of the four weights is added to the larger of the two centre weights. When the two centre weights are equal, it is added to the 0 tap. The four outputs therefore always sum to exactly 256.
- R6: For `frac_u` = 0 the outputs are exactly -1 tap = 0, 0 tap = 256, +1 tap = 0 and +2 tap = 0.
- R7: A position is accepted on a rising edge where both `in_valid` and `in_ready` are high. Its weights are presented with `out_valid` high after the next rising edge, provided that edge is not stalled.
- R8: While `out_ready` stays high, `in_ready` stays high, so a new position is accepted on every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all four weights hold their values. The pipeline stalls, `in_ready` is low, and no accepted position is lost or duplicated.
- R10: While `rst_n` is low and after its release, `out_valid` is low until a position has been accepted, and `in_ready` is high.
- R11: Every presented weight set has both outer weights at or below zero and both centre weights within 0..256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A position is offered on `frac_u` |
| in_ready | output | 1 | The block can take a position this cycle |
| frac_u | input | 8 | Fractional position, value = code/256 |
| out_valid | output | 1 | A weight set is presented |
| out_ready | input | 1 | The consumer takes the presented weight set |
| wt_m1 | output | 16 | Weight of tap at offset -1 |
| wt_c0 | output | 16 | Weight of tap at offset 0 |
| wt_p1 | output | 16 | Weight of tap at offset +1 |
| wt_p2 | output | 16 | Weight of tap at offset +2 |

## Verification
The hardest case to reach is a stall that arrives while both pipeline registers hold accepted positions and a new position is waiting at the input. The weights must then stay frozen and still come out in order once the stall is released. The stimulus reaches this case by offering positions on most cycles while dropping `out_ready` at random for several consecutive cycles. Every presented set is matched in order against a queue of expected sets. The rounding correction depends on the data, so the stimulus also sweeps all 256 codes back to back. This exercises every case where the correction moves a centre weight, including the tie at code 128.

// File: rtl/cwg_pkg.sv
// Package: shared tap naming for the cubic weight generator.
// Assumes four taps at offsets -1, 0, +1, +2, in that index order.
package cwg_pkg;
    localparam int NTAPS = 4;

    typedef enum logic [1:0] {
        TAP_M1 = 2'd0,
        TAP_C0 = 2'd1,
        TAP_P1 = 2'd2,
        TAP_P2 = 2'd3
    } tap_e;
endpackage

// File: rtl/cwg_terms.sv
// Module: exact kernel numerators for the four taps.
// Each numerator is the kernel value times 2^(3*FRAC_W), as an exact
// two's-complement integer. Assumes the fraction lies in [0,1), so the
// outer taps use the far segment and the centre taps use the near segment.
module cwg_terms
    import cwg_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int NUM_W  = 3 * FRAC_W + 4
) (
    input  logic [FRAC_W-1:0]            frac,
    output logic [NTAPS-1:0][NUM_W-1:0]  num
);
    localparam logic [NUM_W-1:0] ONE_F    = NUM_W'(1) << FRAC_W;
    localparam logic [NUM_W-1:0] ONE_CUBE = NUM_W'(1) << (3 * FRAC_W);

    logic [NUM_W-1:0] cc, dd, c_sq, d_sq, c_cu, d_cu;

    // Powers of the fraction and of its complement to one.
    always_comb begin
        cc   = NUM_W'(frac);
        dd   = ONE_F - cc;
        c_sq = cc * cc;
        d_sq = dd * dd;
        c_cu = c_sq * cc;
        d_cu = d_sq * dd;
    end

    // Segment polynomials rewritten in terms of the fraction.
    always_comb begin
        num[TAP_M1] = '0 - (cc * d_sq);
        num[TAP_C0] = ONE_CUBE - (c_sq << (FRAC_W + 1)) + c_cu;
        num[TAP_P1] = ONE_CUBE - (d_sq << (FRAC_W + 1)) + d_cu;
        num[TAP_P2] = '0 - (dd * c_sq);
    end
endmodule

// File: rtl/cwg_round.sv
// Module: scales each exact numerator by 2^SCALE_W and rounds it to the
// nearest integer, halves upward, in a single step.
// Assumes the numerators carry a fixed denominator of 2^(3*FRAC_W).
module cwg_round
    import cwg_pkg::*;
#(
    parameter int FRAC_W  = 8,
    parameter int NUM_W   = 3 * FRAC_W + 4,
    parameter int SCALE_W = 8,
    parameter int WT_W    = 16
) (
    input  logic [NTAPS-1:0][NUM_W-1:0] num,
    output logic [NTAPS-1:0][WT_W-1:0]  wt
);
    localparam int SH_W  = NUM_W + SCALE_W + 1;
    localparam int DEN_W = 3 * FRAC_W;

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        logic signed [SH_W-1:0] scaled;

        // Widen, scale and add the half-unit bias.
        always_comb begin
            scaled = (SH_W'($signed(num[t])) <<< SCALE_W)
                   + (SH_W'(1) <<< (DEN_W - 1));
            wt[t]  = WT_W'(scaled >>> DEN_W);
        end
    end
endmodule

// File: rtl/cwg_balance.sv
// Module: forces the rounded weights to sum to exactly 2^SCALE_W by
// adding the residue to the larger centre weight (the 0 tap on a tie).
// Assumes the residue is small, a few units at most.
module cwg_balance
    import cwg_pkg::*;
#(
    parameter int SCALE_W = 8,
    parameter int WT_W    = 16
) (
    input  logic [NTAPS-1:0][WT_W-1:0] raw,
    output logic [NTAPS-1:0][WT_W-1:0] wt
);
    localparam int SUM_W = WT_W + 3;
    localparam logic signed [SUM_W-1:0] UNITY = SUM_W'(1) <<< SCALE_W;

    logic signed [SUM_W-1:0] total;
    logic signed [SUM_W-1:0] resid;
    logic                    pick_c0;

    // Residue of the rounded set against unity.
    always_comb begin
        total = '0;
        for (int t = 0; t < NTAPS; t++) begin
            total = total + SUM_W'($signed(raw[t]));
        end
        resid   = UNITY - total;
        pick_c0 = $signed(raw[TAP_C0]) >= $signed(raw[TAP_P1]);
    end

    // Residue goes to the dominant centre tap.
    always_comb begin
        wt = raw;
        if (pick_c0) begin
            wt[TAP_C0] = WT_W'($signed(raw[TAP_C0]) + resid);
        end else begin
            wt[TAP_P1] = WT_W'($signed(raw[TAP_P1]) + resid);
        end
    end
endmodule

// File: rtl/cubic_weight_gen.sv
// Module: cubic convolution weight generator, top level.
// Stage 1 registers the exact kernel numerators for an accepted fraction.
// Stage 2 registers the rounded, unity-balanced weights. The whole pipe
// advances together whenever the output register is empty or being taken.
// Assumes a synchronous active-low reset.
module cubic_weight_gen
    import cwg_pkg::*;
#(
    parameter int FRAC_W  = 8,
    parameter int WT_W    = 16,
    parameter int SCALE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FRAC_W-1:0] frac_u,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WT_W-1:0]   wt_m1,
    output logic [WT_W-1:0]   wt_c0,
    output logic [WT_W-1:0]   wt_p1,
    output logic [WT_W-1:0]   wt_p2
);
    localparam int NUM_W = 3 * FRAC_W + 4;

    logic                             advance;
    logic                             s1_valid;
    logic [NTAPS-1:0][NUM_W-1:0]      num_comb, s1_num;
    logic [NTAPS-1:0][WT_W-1:0]       rnd_w, bal_w, s2_w;

    // Pipe moves when the output slot is free or being consumed.
    always_comb begin
        advance  = !out_valid || out_ready;
        in_ready = advance;
    end

    cwg_terms #(.FRAC_W(FRAC_W), .NUM_W(NUM_W)) i_terms (
        .frac (frac_u),
        .num  (num_comb)
    );

    // Stage 1: capture exact numerators of an accepted fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_num   <= '0;
        end else if (advance) begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_num <= num_comb;
            end
        end
    end

    cwg_round #(.FRAC_W(FRAC_W), .NUM_W(NUM_W), .SCALE_W(SCALE_W), .WT_W(WT_W)) i_round (
        .num (s1_num),
        .wt  (rnd_w)
    );

    cwg_balance #(.SCALE_W(SCALE_W), .WT_W(WT_W)) i_balance (
        .raw (rnd_w),
        .wt  (bal_w)
    );

    // Stage 2: present balanced weights, hold them while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            s2_w      <= '0;
        end else if (advance) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                s2_w <= bal_w;
            end
        end
    end

    // Fan the weight vector out to the named tap ports.
    always_comb begin
        wt_m1 = s2_w[TAP_M1];
        wt_c0 = s2_w[TAP_C0];
        wt_p1 = s2_w[TAP_P1];
        wt_p2 = s2_w[TAP_P2];
    end

    // R5: presented weights sum to unity scale.
    a_r5_unity_sum: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((WT_W+3)'($signed(wt_m1)) + (WT_W+3)'($signed(wt_c0))
                     + (WT_W+3)'($signed(wt_p1)) + (WT_W+3)'($signed(wt_p2)))
                     == ((WT_W+3)'(1) << SCALE_W));

    // R11: outer taps never positive.
    a_r11_outer_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(wt_m1) <= 0 && $signed(wt_p2) <= 0));

    // R11: centre taps stay within 0 .. unity.
    a_r11_centre_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(wt_c0) >= 0 && $signed(wt_p1) >= 0
                   && $signed(wt_c0) <= (1 << SCALE_W)
                   && $signed(wt_p1) <= (1 << SCALE_W)));

    // R7: an accepted fraction occupies stage 1 next cycle.
    a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_valid);

    // R7: a stage-1 item moves to the output on an unstalled edge.
    a_r7_present: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && in_ready) |=> out_valid);

    // R9: stalled output keeps valid and data.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(wt_m1) && $stable(wt_c0)
                                      && $stable(wt_p1) && $stable(wt_p2)));
endmodule

// File: tb/test_cubic_weight_gen.sv
// Scoreboard bench: a driver pushes expected weight sets at acceptance,
// a monitor pops and compares them as sets are taken at the output.
module test_cubic_weight_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  frac_u;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] wt_m1, wt_c0, wt_p1, wt_p2;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [63:0] expq[$];

    always #5 clk = ~clk;

    cubic_weight_gen i_cubic_weight_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .frac_u(frac_u), .out_valid(out_valid), .out_ready(out_ready),
        .wt_m1(wt_m1), .wt_c0(wt_c0), .wt_p1(wt_p1), .wt_p2(wt_p2)
    );

    // Reference weights from the requirement formulas (R2, R3, R4, R5).
    function automatic logic [63:0] ref_set(input int code);
        longint c = code;
        longint d = 256 - code;
        longint n[4];
        longint w[4];
        longint s;
        n[0] = -(c * d * d);
        n[1] = 64'sd16777216 - 512 * c * c + c * c * c;
        n[2] = 64'sd16777216 - 512 * d * d + d * d * d;
        n[3] = -(d * c * c);
        for (int k = 0; k < 4; k++) w[k] = (n[k] * 256 + 64'sd8388608) >>> 24;
        s = w[0] + w[1] + w[2] + w[3];
        if (w[1] >= w[2]) w[1] = w[1] + (256 - s);
        else              w[2] = w[2] + (256 - s);
        return {w[0][15:0], w[1][15:0], w[2][15:0], w[3][15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: offers positions, pushes the expected set on acceptance.
    task automatic stream(input int n, input bit sweep, input int stall_pct, input int gap_pct);
        int sent = 0;
        int lfail = 0;
        while (sent < n) begin
            @(negedge clk);
            out_ready = (stall_pct == 0) ? 1'b1 : (($urandom % 100) >= stall_pct);
            in_valid  = (gap_pct == 0) ? 1'b1 : (($urandom % 100) >= gap_pct);
            frac_u    = sweep ? 8'(sent) : 8'($urandom);
            #1;
            if (stall_pct == 0 && !in_ready) lfail++;
            if (in_valid && in_ready) begin
                expq.push_back(ref_set(int'(frac_u)));
                sent++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (stall_pct == 0) check(lfail == 0, "R8 in_ready high every cycle", 64'(lfail), 64'd0);
    endtask

    // Monitor: compares taken sets in order and checks stall holds.
    bit          hold_pend = 0;
    logic [63:0] held;
    always @(negedge clk) begin
        #2;
        if (rst_n === 1'b1) begin
            if (hold_pend)
                check(out_valid && {wt_m1, wt_c0, wt_p1, wt_p2} == held, "R9 hold while stalled",
                      {wt_m1, wt_c0, wt_p1, wt_p2}, held);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R7 unexpected output", {wt_m1, wt_c0, wt_p1, wt_p2}, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    check({wt_m1, wt_c0, wt_p1, wt_p2} == e, "R1 R2 R3 R4 R5 weight set",
                          {wt_m1, wt_c0, wt_p1, wt_p2}, e);
                    check($signed(wt_m1) <= 0 && $signed(wt_p2) <= 0 && $signed(wt_c0) >= 0
                          && $signed(wt_p1) >= 0 && $signed(wt_c0) <= 256 && $signed(wt_p1) <= 256,
                          "R11 weight signs", {wt_m1, wt_c0, wt_p1, wt_p2}, e);
                end
            end
            hold_pend = out_valid && !out_ready;
            held      = {wt_m1, wt_c0, wt_p1, wt_p2};
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; frac_u = '0;
        repeat (3) @(negedge clk);
        #1 check(out_valid == 1'b0, "R10 out_valid low in reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(out_valid == 1'b0 && in_ready == 1'b1, "R10 idle after reset",
                 {62'd0, out_valid, in_ready}, 64'd1);

        // R6 and R7: single zero position, latency check.
        @(negedge clk);
        in_valid = 1'b1; frac_u = 8'd0;
        #1 expq.push_back(ref_set(0));
        @(negedge clk);
        in_valid = 1'b0;
        #1 check(out_valid == 1'b0, "R7 not yet presented", 64'(out_valid), 64'd0);
        @(negedge clk);
        #1 check(out_valid == 1'b1 && {wt_m1, wt_c0, wt_p1, wt_p2} == {16'd0, 16'd256, 16'd0, 16'd0},
                 "R6 zero position weights", {wt_m1, wt_c0, wt_p1, wt_p2},
                 {16'd0, 16'd256, 16'd0, 16'd0});
        @(negedge clk);

        // R8 plus R2..R5: full sweep back to back.
        stream(256, 1'b1, 0, 0);
        // R9: heavy back-pressure with full pipe.
        stream(300, 1'b0, 45, 10);
        // Mixed gaps and stalls.
        stream(300, 1'b0, 20, 40);

        out_ready = 1'b1;
        repeat (8) @(negedge clk);
        #3 check(expq.size() == 0, "R9 nothing lost", 64'(expq.size()), 64'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule